// File: doc/BRIEF.md
# Infrared pulse run-length sampler

This block watches one infrared receiver line and turns its waveform into a stream of run-length bytes. The line is brought into the clock domain by a short flop chain and may be inverted. It is then sampled once per strobe on a sample-rate enable input, for example a 125 kHz strobe (one sample every 8 µs) taken from an 8 MHz clock divided by 64. Each time the sampled level changes, the finished run leaves the block as one byte. The top bit of the byte holds the level. The low bits hold the run length in samples, minus one.

Two programmable thresholds shape the stream. A noise threshold drops runs that are too short to be real carrier bursts. An idle threshold, counted in units of 128 samples, ends a packet when the line rests at the space level for long enough. At that point the block raises a packet-end pulse and stops output until the next pulse arrives. Runs longer than the duration field can hold are cut into full-scale chunks. The stream is meant to feed a FIFO and a software or hardware protocol decoder, and neither of those is part of this block.

Top module: `ir_runlen_sampler`

## Requirements
- R1: While rst_n is low, byte_vld_o, byte_o and pkt_end_o are all zero.
- R2: Sampling happens only when glob_en_i, rx_en_i and mode_i == 2'b11 all hold together. In any other state no byte and no packet end is produced, and all run state is cleared.
- R3: Outputs are registered. byte_vld_o and pkt_end_o go high for one clock, only in the clock after an edge at which sample_en_i was high. The line goes through a two-flop synchronizer first.
- R4: An emitted byte carries the sampled level in bit 7 (1 = pulse, 0 = space) and the run length minus one in bits 6:0. With invert_i low, a high raw line is a pulse.
- R5: With invert_i high, the raw line is inverted before sampling, so a low raw line is a pulse.
- R6: A run of at most noise_thr_i samples that is shorter than 128 samples is dropped without a byte. The runs on either side of it are not merged. A threshold of 0 drops nothing.
- R7: Every full 128 samples of one run emit a byte {level, 7'h7F} as soon as they are counted. A nonzero remainder is emitted at the level change, and it is exempt from the noise threshold.
- R8: When a space run reaches (idle_thr_i+1)*128 samples, the last 128-sample chunk {0, 7'h7F} is emitted and pkt_end_o rises in the same cycle. The rest of that space produces nothing.
- R9: After enabling and after each packet end, space samples are ignored until the first pulse sample. That sample starts a new run of length 1.
- R10: Clearing an enable in the middle of a run discards the partial run without a byte.
- R11: pkt_end_o is never high in two consecutive cycles, and it fires once per idle period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ir_raw_i | input | 1 | Raw infrared receiver line, asynchronous |
| sample_en_i | input | 1 | One-clock sample strobe at the sample rate |
| glob_en_i | input | 1 | Global enable |
| rx_en_i | input | 1 | Receive enable |
| mode_i | input | 2 | Operating mode; 2'b11 selects run-length sampling |
| invert_i | input | 1 | Invert the line before sampling |
| noise_thr_i | input | 6 | Noise threshold in samples |
| idle_thr_i | input | 8 | Idle threshold in units of 128 samples, minus one |
| byte_vld_o | output | 1 | Byte strobe, one clock |
| byte_o | output | 8 | Level flag and duration minus one |
| pkt_end_o | output | 1 | Packet-end strobe, one clock |

## Verification
Two functions can fire on the same sampling edge: the full-scale chunk split and the idle packet end. The idle limit is always a multiple of 128 samples, so the closing chunk of a long space is emitted in the same cycle as pkt_end_o. The bench provokes this with trailing spaces that are shorter than, exactly equal to, and longer than the limit, for two idle settings. At every packet end it requires the strobe, the byte 8'h7F and the recorded stream position all to agree with a run-based arithmetic model.

// File: rtl/ir_rl_pkg.sv
package ir_rl_pkg;

  typedef enum logic {
    LVL_SPACE = 1'b0,
    LVL_MARK  = 1'b1
  } ir_level_e;

  localparam logic [1:0] MODE_RUNLEN = 2'b11;

  // Run survives the noise filter when it was split at least once or is
  // strictly longer than the threshold.
  function automatic logic run_survives(input int run_len, input int thr,
                                        input logic was_split);
    return was_split || (run_len > thr);
  endfunction

  // Idle limit in samples: (thr + 1) chunks of 2**unit_log2 samples.
  function automatic int idle_limit(input int thr, input int unit_log2);
    return (thr + 1) << unit_log2;
  endfunction

endpackage

// File: rtl/ir_rl_sync.sv
module ir_rl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic invert,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1] ^ invert;
endmodule

// File: rtl/ir_rl_idle_det.sv
module ir_rl_idle_det #(
  parameter int DUR_W  = 7,
  parameter int IDLE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              tick,
  input  logic              armed,
  input  logic              lvl_s,
  input  logic              cur_lvl,
  input  logic [IDLE_W-1:0] idle_thr,
  output logic              idle_hit
);
  import ir_rl_pkg::*;

  localparam int ICW = IDLE_W + DUR_W + 1;

  logic [ICW-1:0] space_cnt_q;
  logic [ICW-1:0] limit;
  logic           step;
  logic           in_space;

  assign limit    = (ICW'(idle_thr) + ICW'(1)) << DUR_W;
  assign step     = active && tick && armed;
  assign in_space = (lvl_s == LVL_SPACE) && (cur_lvl == LVL_SPACE);
  assign idle_hit = step && in_space && ((space_cnt_q + ICW'(1)) == limit);

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      space_cnt_q <= '0;
    end else if (tick) begin
      if (!armed || idle_hit) begin
        space_cnt_q <= '0;
      end else if (lvl_s != cur_lvl) begin
        space_cnt_q <= (lvl_s == LVL_SPACE) ? ICW'(1) : '0;
      end else if (lvl_s == LVL_SPACE) begin
        space_cnt_q <= space_cnt_q + ICW'(1);
      end
    end
  end
endmodule

// File: rtl/ir_rl_run_track.sv
module ir_rl_run_track #(
  parameter int DUR_W   = 7,
  parameter int NOISE_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic               tick,
  input  logic               lvl_s,
  input  logic [NOISE_W-1:0] noise_thr,
  input  logic               idle_hit,
  output logic               armed,
  output logic               cur_lvl,
  output logic               drop_evt,
  output logic               split_evt,
  output logic               byte_vld,
  output logic [DUR_W:0]     byte_q,
  output logic               pkt_end
);
  import ir_rl_pkg::*;

  localparam logic [DUR_W-1:0] CNT_FULL = {DUR_W{1'b1}};

  logic [DUR_W-1:0] cnt_q;
  logic             split_q;
  logic             step;
  logic             same_lvl;
  logic             run_end;
  logic             has_run;
  logic             keep_run;
  logic             emit_end;

  assign step      = active && tick;
  assign same_lvl  = (lvl_s == cur_lvl);
  assign run_end   = step && armed && !same_lvl;
  assign has_run   = (cnt_q != '0);
  assign keep_run  = run_survives(int'(cnt_q), int'(noise_thr), split_q);
  assign emit_end  = run_end && has_run && keep_run;
  assign drop_evt  = run_end && has_run && !keep_run;
  assign split_evt = step && armed && same_lvl && (cnt_q == CNT_FULL);

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      armed    <= 1'b0;
      cur_lvl  <= LVL_SPACE;
      cnt_q    <= '0;
      split_q  <= 1'b0;
      byte_vld <= 1'b0;
      byte_q   <= '0;
      pkt_end  <= 1'b0;
    end else begin
      byte_vld <= 1'b0;
      pkt_end  <= 1'b0;
      if (tick) begin
        if (!armed) begin
          if (lvl_s == LVL_MARK) begin
            armed   <= 1'b1;
            cur_lvl <= LVL_MARK;
            cnt_q   <= DUR_W'(1);
            split_q <= 1'b0;
          end
        end else if (same_lvl) begin
          if (split_evt) begin
            byte_vld <= 1'b1;
            byte_q   <= {cur_lvl, CNT_FULL};
            cnt_q    <= '0;
            split_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
          if (idle_hit) begin
            armed   <= 1'b0;
            cnt_q   <= '0;
            split_q <= 1'b0;
            pkt_end <= 1'b1;
          end
        end else begin
          if (emit_end) begin
            byte_vld <= 1'b1;
            byte_q   <= {cur_lvl, cnt_q - 1'b1};
          end
          cur_lvl <= lvl_s;
          cnt_q   <= DUR_W'(1);
          split_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/ir_runlen_sampler.sv
module ir_runlen_sampler #(
  parameter int DUR_W       = 7,
  parameter int NOISE_W     = 6,
  parameter int IDLE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ir_raw_i,
  input  logic               sample_en_i,
  input  logic               glob_en_i,
  input  logic               rx_en_i,
  input  logic [1:0]         mode_i,
  input  logic               invert_i,
  input  logic [NOISE_W-1:0] noise_thr_i,
  input  logic [IDLE_W-1:0]  idle_thr_i,
  output logic               byte_vld_o,
  output logic [DUR_W:0]     byte_o,
  output logic               pkt_end_o
);
  import ir_rl_pkg::*;

  logic run_active;
  logic lvl_s;
  logic armed;
  logic cur_lvl;
  logic idle_hit;
  logic drop_evt;
  logic split_evt;

  assign run_active = glob_en_i && rx_en_i && (mode_i == MODE_RUNLEN);

  ir_rl_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .din    (ir_raw_i),
    .invert (invert_i),
    .dout   (lvl_s)
  );

  ir_rl_idle_det #(.DUR_W(DUR_W), .IDLE_W(IDLE_W)) idle_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (run_active),
    .tick     (sample_en_i),
    .armed    (armed),
    .lvl_s    (lvl_s),
    .cur_lvl  (cur_lvl),
    .idle_thr (idle_thr_i),
    .idle_hit (idle_hit)
  );

  ir_rl_run_track #(.DUR_W(DUR_W), .NOISE_W(NOISE_W)) track_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (run_active),
    .tick      (sample_en_i),
    .lvl_s     (lvl_s),
    .noise_thr (noise_thr_i),
    .idle_hit  (idle_hit),
    .armed     (armed),
    .cur_lvl   (cur_lvl),
    .drop_evt  (drop_evt),
    .split_evt (split_evt),
    .byte_vld  (byte_vld_o),
    .byte_q    (byte_o),
    .pkt_end   (pkt_end_o)
  );
endmodule

// File: rtl/ir_rl_sva.sv
module ir_rl_sva #(
  parameter int DUR_W = 7
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sample_en_i,
  input logic           run_active,
  input logic           drop_evt,
  input logic           byte_vld_o,
  input logic [DUR_W:0] byte_o,
  input logic           pkt_end_o
);
  localparam logic [DUR_W:0] LAST_SPACE = {1'b0, {DUR_W{1'b1}}};

  assert_gated_output_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!run_active) |-> (!byte_vld_o && !pkt_end_o));

  assert_strobe_after_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld_o || pkt_end_o) |-> $past(sample_en_i));

  assert_short_run_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> !byte_vld_o);

  assert_end_with_chunk_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end_o |-> (byte_vld_o && byte_o == LAST_SPACE));

  assert_single_pkt_end_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_end_o |=> !pkt_end_o);
endmodule

bind ir_runlen_sampler ir_rl_sva #(.DUR_W(DUR_W)) sva_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .sample_en_i (sample_en_i),
  .run_active  (run_active),
  .drop_evt    (drop_evt),
  .byte_vld_o  (byte_vld_o),
  .byte_o      (byte_o),
  .pkt_end_o   (pkt_end_o)
);

// File: tb/ir_runlen_sampler_tb_top.sv
`timescale 1ns/1ps
module ir_runlen_sampler_tb_top;
  localparam int CLK_PER = 10;
  localparam int WD_CYC  = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ir_raw = 1'b0;
  logic       tick = 1'b0;
  logic       glob_en = 1'b0;
  logic       rx_en = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       invert = 1'b0;
  logic [5:0] noise_thr = '0;
  logic [7:0] idle_thr = '0;
  logic       byte_vld;
  logic [7:0] byte_d;
  logic       pkt_end;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  bit pkt_prev = 1'b0;

  logic [7:0] got_q[$];
  logic [7:0] exp_q[$];
  int         got_pkt[$];
  int         exp_pkt[$];
  int         run_lv[$];
  int         run_ln[$];

  always #(CLK_PER/2) clk = ~clk;

  ir_runlen_sampler dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ir_raw_i    (ir_raw),
    .sample_en_i (tick),
    .glob_en_i   (glob_en),
    .rx_en_i     (rx_en),
    .mode_i      (mode),
    .invert_i    (invert),
    .noise_thr_i (noise_thr),
    .idle_thr_i  (idle_thr),
    .byte_vld_o  (byte_vld),
    .byte_o      (byte_d),
    .pkt_end_o   (pkt_end)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Monitor: a quarter period after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PER/4);
      if (rst_n) begin
        if (byte_vld || pkt_end)
          chk(tick == 1'b1, "R3 strobe without sample edge", int'(tick), 1);
        if (byte_vld) got_q.push_back(byte_d);
        if (pkt_end) begin
          chk(byte_vld && byte_d == 8'h7F, "R8 packet end with last chunk",
              int'(byte_d), 8'h7F);
          got_pkt.push_back(got_q.size());
        end
        if (pkt_end && pkt_prev)
          chk(1'b0, "R11 packet end twice in a row", 1, 0);
        pkt_prev = pkt_end;
      end
    end
  end

  // One sample of logical level v: the line settles through the
  // synchronizer before the strobe.
  task automatic sample(input int v);
    @(negedge clk);
    ir_raw = (v != 0) ^ invert;
    repeat (2) @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic add_run(input int v, input int len);
    run_lv.push_back(v);
    run_ln.push_back(len);
  endtask

  task automatic play_runs();
    foreach (run_lv[i])
      for (int k = 0; k < run_ln[i]; k++) sample(run_lv[i]);
    repeat (3) @(negedge clk);
  endtask

  // Run-based expectation, computed from the requirements.
  task automatic build_expected();
    bit armed = 1'b0;
    int nthr = int'(noise_thr);
    int lim = (int'(idle_thr) + 1) * 128;
    foreach (run_lv[i]) begin
      int v = run_lv[i];
      int len = run_ln[i];
      if (!armed) begin
        if (v == 0) continue;
        armed = 1'b1;
      end
      if (v == 0 && len >= lim) begin
        for (int j = 0; j < lim / 128; j++) exp_q.push_back(8'h7F);
        exp_pkt.push_back(exp_q.size());
        armed = 1'b0;
      end else begin
        int r = len % 128;
        for (int j = 0; j < len / 128; j++) exp_q.push_back(8'(v * 128 + 127));
        if (r > 0 && (len >= 128 || r > nthr)) exp_q.push_back(8'(v * 128 + r - 1));
      end
    end
  endtask

  task automatic compare(input string req);
    chk(got_q.size() == exp_q.size(), {req, " byte count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk(got_q[i] == exp_q[i], {req, " byte value"}, int'(got_q[i]), int'(exp_q[i]));
    chk(got_pkt.size() == exp_pkt.size(), {req, " R11 packet end count"},
        got_pkt.size(), exp_pkt.size());
    for (int i = 0; i < exp_pkt.size() && i < got_pkt.size(); i++)
      chk(got_pkt[i] == exp_pkt[i], {req, " R8 packet end position"}, got_pkt[i], exp_pkt[i]);
    got_q.delete(); exp_q.delete(); got_pkt.delete(); exp_pkt.delete();
    run_lv.delete(); run_ln.delete();
  endtask

  task automatic run_case(input string req);
    play_runs();
    build_expected();
    compare(req);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog expired", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(byte_vld == 1'b0, "R1 byte_vld in reset", int'(byte_vld), 0);
    chk(byte_d == 8'h00, "R1 byte in reset", int'(byte_d), 0);
    chk(pkt_end == 1'b0, "R1 pkt_end in reset", int'(pkt_end), 0);
    @(negedge clk);
    rst_n = 1'b1;
    glob_en = 1'b1; rx_en = 1'b1; mode = 2'b11; idle_thr = 8'd0;

    // R4 R6 R9: noise threshold sweep with leading ignored space.
    for (int t = 0; t <= 5; t++) begin
      noise_thr = 6'(t);
      add_run(0, 5);
      for (int k = 1; k <= 8; k++) begin
        add_run(1, k);
        add_run(0, (k == 8) ? 140 : 9 - k);
      end
      run_case("R6 R4 R9 noise sweep");
    end

    // R7: long runs, splits, exact 128, dropped short runs, idle of 256.
    noise_thr = 6'd3; idle_thr = 8'd1;
    add_run(0, 3); add_run(1, 300); add_run(0, 200); add_run(1, 128);
    add_run(0, 2); add_run(1, 256); add_run(0, 255); add_run(1, 1);
    add_run(0, 300);
    run_case("R7 long runs");

    // R5 R8: inverted line, space exactly at the idle limit, then rearm.
    invert = 1'b1; noise_thr = 6'd0; idle_thr = 8'd0;
    add_run(1, 3); add_run(0, 4); add_run(1, 130); add_run(0, 128);
    add_run(1, 2); add_run(0, 140);
    run_case("R5 R8 inverted line");
    invert = 1'b0;

    // R2: gating by mode and by each enable.
    mode = 2'b10;
    add_run(1, 10); add_run(0, 140);
    play_runs();
    compare("R2 mode not 2'b11");
    mode = 2'b11; glob_en = 1'b0;
    add_run(1, 10); add_run(0, 140);
    play_runs();
    compare("R2 global enable low");
    glob_en = 1'b1; rx_en = 1'b0;
    add_run(1, 10); add_run(0, 140);
    play_runs();
    compare("R2 receive enable low");
    rx_en = 1'b1;

    // R10: disable in the middle of a pulse run.
    add_run(1, 50);
    play_runs();
    rx_en = 1'b0;
    repeat (3) @(negedge clk);
    chk(got_q.size() == 0, "R10 partial run emitted", got_q.size(), 0);
    rx_en = 1'b1;
    run_lv.delete(); run_ln.delete();
    add_run(0, 3); add_run(1, 5); add_run(0, 140);
    run_case("R10 restart after disable");

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule